// File: doc/BRIEF.md
# Shared Tagged Receive FIFO

This block gathers received characters from four serial lines into one shared queue. Each character is stored as a 16-bit word. The word holds the byte, the number of the line the byte came from, a valid marker and three error flags. Software drains the queue through one read strobe and gets the words back in the order they arrived. A receive-done flag tells software that words are waiting, and a count output gives the current fill.

Every line has two sources of characters. The first is its receiver, which supplies the byte and its error bits. The second is a loopback path: when loopback is on, each finished transmit character is queued as though it had been received, with no error bits set. The block latches each request in a pending slot of its own. A fixed-priority arbiter then moves one slot per cycle into the storage array, lowest line first. A synchronous master clear empties the queue and discards every pending request.

Top module: `tagged_rx_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 64) words in a circular store. Words are read out in the order they were written, and `fillCount` never goes above DEPTH.
- R2: A stored word has the valid marker in bit 15, overrun in bit 14, framing error in bit 13 and parity error in bit 12. Bits 11:10 are zero, the line number is in bits 9:8 and the character is in bits 7:0. A receive request's error input for a line is {overrun, framing, parity}, with overrun as its most significant bit.
- R3: Every word accepted into the store sets `rxDone`. A read that leaves the count at zero clears it, unless a word is accepted in the same cycle. `rxDone` is high whenever `fillCount` is non-zero.
- R4: A read strobe while the queue is empty returns 0x0000 in `rdWord`, clears `rxDone` and changes neither the count nor the read order.
- R5: When a pending word meets a full queue (count equal to DEPTH in that cycle), the word is discarded and the stored words are unchanged. `rxDropped` goes high for the one cycle that follows the discard.
- R6: Reset and master clear both set the count to zero and set `rxDone` and `rdWord` to zero. They also discard all pending requests, including requests that arrive in the same cycle as the clear.
- R7: While `loopEn` is high, a `txDone` pulse on line i queues a word with bit 15 set, bits 14:12 zero, line i in bits 9:8 and the transmit character in bits 7:0.
- R8: Pending slots are served one per cycle in this fixed order: line 0 receive, line 0 loopback, line 1 receive, line 1 loopback, and so on up to line 3. A slot that is not served stays pending.
- R9: A request made in cycle t shows in `fillCount` and `rxDone` after the second rising edge, if no other slot is ahead of it. `rdWord` is registered and changes at the edge that samples the read strobe. If a word is accepted and a word is read at the same edge, the count does not change.
- R10: A new request on a source whose earlier request is still pending replaces the earlier one. If that slot is served at the same edge, the earlier word is the one served and the new word becomes pending.
- R11: While `loopEn` is low, `txDone` pulses have no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterClear | input | 1 | Synchronous clear of the queue and of all pending slots |
| rxReq | input | NUM_LINES | Per-line strobe: a received character is ready |
| rxChar | input | NUM_LINES*8 | Per-line received character, line i in bits 8i+7:8i |
| rxErr | input | NUM_LINES*3 | Per-line {overrun, framing, parity} bits, line i in bits 3i+2:3i |
| loopEn | input | 1 | Loopback enable |
| txDone | input | NUM_LINES | Per-line strobe: a transmit character has finished |
| txChar | input | NUM_LINES*8 | Per-line transmitted character |
| rdStrobe | input | 1 | Host read strobe; pops one word |
| rdWord | output | 16 | Registered read word |
| rxDone | output | 1 | Receive-done flag |
| fillCount | output | $clog2(DEPTH+1) | Number of stored words |
| rxDropped | output | 1 | One-cycle pulse after a word is discarded at full |

## Verification
The bench builds the block with NUM_LINES=4 and DEPTH=64, so it has eight pending slots and a 7-bit count. A depth of 64 is small enough that a directed burst of 66 back-to-back pushes fills the store and hits the discard path. It is also large enough that random phases with a low read rate reach full and then drain back to empty many times. With four lines and loopback on, all eight arbitration positions can compete in the same cycle, and random bursts land on slots that are still pending. This exercises the replacement rule.

// File: rtl/tagged_rx_pkg.sv
package tagged_rx_pkg;

  localparam int ENTRY_W = 16;
  localparam int CHAR_W  = 8;
  localparam int ERR_W   = 3;
  localparam int TAG_W   = 2;

  // one stored word; field order is the bit layout seen by the host
  typedef struct packed {
    logic              valid;
    logic              overrun;
    logic              framing;
    logic              parity;
    logic [1:0]        spare;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] dataByte;
  } rx_entry_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;
    logic popEn;
    logic zeroRead;
    logic clr;
  } fifo_strobe_t;

endpackage

// File: rtl/tagged_rx_ingress.sv
module tagged_rx_ingress
  import tagged_rx_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          clr,
  input  logic [NUM_LINES-1:0]          rxReq,
  input  logic [NUM_LINES*CHAR_W-1:0]   rxChar,
  input  logic [NUM_LINES*ERR_W-1:0]    rxErr,
  input  logic                          loopEn,
  input  logic [NUM_LINES-1:0]          txDone,
  input  logic [NUM_LINES*CHAR_W-1:0]   txChar,
  output logic                          candValid,
  output rx_entry_t                     candEntry
);

  localparam int NUM_SLOTS = 2 * NUM_LINES;

  logic [NUM_SLOTS-1:0] slotValid;
  logic [NUM_SLOTS-1:0] slotLoad;
  logic [NUM_SLOTS-1:0] grant;
  rx_entry_t            slotEntry [NUM_SLOTS];
  rx_entry_t            loadEntry [NUM_SLOTS];

  // two sources per line: even slot = receiver, odd slot = loopback
  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    assign slotLoad[2*gi]  = rxReq[gi];
    assign loadEntry[2*gi] = '{valid:    1'b1,
                               overrun:  rxErr[gi*ERR_W+2],
                               framing:  rxErr[gi*ERR_W+1],
                               parity:   rxErr[gi*ERR_W],
                               spare:    2'b00,
                               line:     TAG_W'(gi),
                               dataByte: rxChar[gi*CHAR_W +: CHAR_W]};

    assign slotLoad[2*gi+1]  = loopEn & txDone[gi];
    assign loadEntry[2*gi+1] = '{valid:    1'b1,
                                 overrun:  1'b0,
                                 framing:  1'b0,
                                 parity:   1'b0,
                                 spare:    2'b00,
                                 line:     TAG_W'(gi),
                                 dataByte: txChar[gi*CHAR_W +: CHAR_W]};
  end

  for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
    logic      validQ;
    rx_entry_t entryQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        entryQ <= '0;
      end else if (clr) begin
        validQ <= 1'b0;
      end else if (slotLoad[gs]) begin
        validQ <= 1'b1;
        entryQ <= loadEntry[gs];
      end else if (grant[gs]) begin
        validQ <= 1'b0;
      end
    end

    assign slotValid[gs] = validQ;
    assign slotEntry[gs] = entryQ;
  end

  // fixed priority: lowest slot index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotValid[s] && !taken) begin
        grant[s] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    candEntry = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (grant[s]) candEntry = slotEntry[s];
    end
  end

  assign candValid = |slotValid;

endmodule

// File: rtl/tagged_rx_ctrl.sv
module tagged_rx_ctrl
  import tagged_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          masterClear,
  input  logic          candValid,
  input  logic          rdStrobe,
  output fifo_strobe_t  strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] fillCount,
  output logic          rxDone,
  output logic          rxDropped
);

  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_ADDR  = AW'(DEPTH - 1);

  logic isFull;
  logic isEmpty;

  assign isFull  = (fillCount == FULL_COUNT);
  assign isEmpty = (fillCount == '0);

  always_comb begin
    strobe.clr      = masterClear;
    strobe.wrEn     = candValid & ~isFull  & ~masterClear;
    strobe.popEn    = rdStrobe  & ~isEmpty & ~masterClear;
    strobe.zeroRead = rdStrobe  &  isEmpty & ~masterClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
    end else if (strobe.clr) begin
      wrAddr <= '0;
    end else if (strobe.wrEn) begin
      wrAddr <= (wrAddr == LAST_ADDR) ? '0 : wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
    end else if (strobe.clr) begin
      rdAddr <= '0;
    end else if (strobe.popEn) begin
      rdAddr <= (rdAddr == LAST_ADDR) ? '0 : rdAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else if (strobe.clr) begin
      fillCount <= '0;
    end else begin
      case ({strobe.wrEn, strobe.popEn})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // an accepted word sets the flag; emptying it or reading it empty clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDone <= 1'b0;
    end else if (strobe.clr) begin
      rxDone <= 1'b0;
    end else if (strobe.wrEn) begin
      rxDone <= 1'b1;
    end else if ((strobe.popEn && fillCount == CW'(1)) || strobe.zeroRead) begin
      rxDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxDropped <= 1'b0;
    else       rxDropped <= candValid & isFull & ~masterClear;
  end

endmodule

// File: rtl/tagged_rx_datapath.sv
module tagged_rx_datapath
  import tagged_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifo_strobe_t       strobe,
  input  logic [AW-1:0]      wrAddr,
  input  logic [AW-1:0]      rdAddr,
  input  rx_entry_t          wrEntry,
  output logic [ENTRY_W-1:0] rdWord
);

  rx_entry_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrAddr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord <= '0;
    end else if (strobe.clr || strobe.zeroRead) begin
      rdWord <= '0;
    end else if (strobe.popEn) begin
      rdWord <= store[rdAddr];
    end
  end

endmodule

// File: rtl/tagged_rx_fifo.sv
module tagged_rx_fifo
  import tagged_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          masterClear,
  input  logic [NUM_LINES-1:0]          rxReq,
  input  logic [NUM_LINES*8-1:0]        rxChar,
  input  logic [NUM_LINES*3-1:0]        rxErr,
  input  logic                          loopEn,
  input  logic [NUM_LINES-1:0]          txDone,
  input  logic [NUM_LINES*8-1:0]        txChar,
  input  logic                          rdStrobe,
  output logic [15:0]                   rdWord,
  output logic                          rxDone,
  output logic [$clog2(DEPTH+1)-1:0]    fillCount,
  output logic                          rxDropped
);

  localparam int AW = $clog2(DEPTH);

  logic         candValid;
  rx_entry_t    candEntry;
  fifo_strobe_t strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  tagged_rx_ingress #(.NUM_LINES(NUM_LINES)) u_ingress (
    .clk       (clk),
    .rstN      (rstN),
    .clr       (masterClear),
    .rxReq     (rxReq),
    .rxChar    (rxChar),
    .rxErr     (rxErr),
    .loopEn    (loopEn),
    .txDone    (txDone),
    .txChar    (txChar),
    .candValid (candValid),
    .candEntry (candEntry)
  );

  tagged_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .masterClear (masterClear),
    .candValid   (candValid),
    .rdStrobe    (rdStrobe),
    .strobe      (strobe),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fillCount   (fillCount),
    .rxDone      (rxDone),
    .rxDropped   (rxDropped)
  );

  tagged_rx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrEntry (candEntry),
    .rdWord  (rdWord)
  );

endmodule

// File: rtl/tagged_rx_fifo_chk.sv
module tagged_rx_fifo_chk #(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       masterClear,
  input logic                       rdStrobe,
  input logic [15:0]                rdWord,
  input logic                       rxDone,
  input logic [$clog2(DEPTH+1)-1:0] fillCount,
  input logic                       rxDropped
);

  // R1: the fill never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillCount) <= DEPTH);

  // R2: a read from a non-empty queue yields a word with the valid marker
  p_valid_marker_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fillCount != '0 && !masterClear) |=> rdWord[15]);

  // R3: stored words imply the done flag
  p_done_tracks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount != '0) |-> rxDone);

  // R4: reading an empty queue returns zero
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fillCount == '0 && !masterClear) |=> (rdWord == 16'h0000));

  // R5: a discard is only reported after a full cycle
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxDropped |-> (int'($past(fillCount)) == DEPTH));

  // R6: master clear empties everything
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    masterClear |=> (fillCount == '0 && !rxDone && rdWord == 16'h0000));

  // R9: the count moves by at most one per cycle
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    !masterClear |=> (int'(fillCount) == int'($past(fillCount)) ||
                      int'(fillCount) == int'($past(fillCount)) + 1 ||
                      int'(fillCount) + 1 == int'($past(fillCount))));

endmodule

bind tagged_rx_fifo tagged_rx_fifo_chk #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .masterClear (masterClear),
  .rdStrobe    (rdStrobe),
  .rdWord      (rdWord),
  .rxDone      (rxDone),
  .fillCount   (fillCount),
  .rxDropped   (rxDropped)
);

// File: tb/tagged_rx_fifo_tb.sv
module tagged_rx_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 4;
  localparam int DEPTH      = 64;
  localparam int SLOTS      = 2 * LINES;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     masterClear = 1'b0;
  logic [LINES-1:0]         rxReq = '0;
  logic [LINES*8-1:0]       rxChar = '0;
  logic [LINES*3-1:0]       rxErr = '0;
  logic                     loopEn = 1'b0;
  logic [LINES-1:0]         txDone = '0;
  logic [LINES*8-1:0]       txChar = '0;
  logic                     rdStrobe = 1'b0;
  logic [15:0]              rdWord;
  logic                     rxDone;
  logic [$clog2(DEPTH+1)-1:0] fillCount;
  logic                     rxDropped;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [15:0] q[$];
  bit          slotV [SLOTS];
  logic [15:0] slotE [SLOTS];
  logic        mDone = 1'b0;
  logic [15:0] mRd   = '0;
  logic        mDrop = 1'b0;

  tagged_rx_fifo #(.NUM_LINES(LINES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .masterClear(masterClear),
    .rxReq(rxReq), .rxChar(rxChar), .rxErr(rxErr),
    .loopEn(loopEn), .txDone(txDone), .txChar(txChar),
    .rdStrobe(rdStrobe), .rdWord(rdWord), .rxDone(rxDone),
    .fillCount(fillCount), .rxDropped(rxDropped)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mkRx(int line, logic [7:0] ch, logic [2:0] err);
    return {1'b1, err, 2'b00, 2'(line), ch};
  endfunction

  function automatic logic [15:0] mkLb(int line, logic [7:0] ch);
    return {1'b1, 3'b000, 2'b00, 2'(line), ch};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int  sz;
    int  g;
    bit  acc;
    bit  pop;
    bit  zr;
    sz = q.size();
    if (masterClear) begin
      q.delete();
      for (int s = 0; s < SLOTS; s++) slotV[s] = 0;
      mDone = 1'b0; mRd = '0; mDrop = 1'b0;
    end else begin
      g = -1;
      for (int s = 0; s < SLOTS; s++) if (slotV[s] && g < 0) g = s;
      acc   = (g >= 0) && (sz < DEPTH);
      mDrop = (g >= 0) && (sz >= DEPTH);
      pop   = rdStrobe && sz > 0;
      zr    = rdStrobe && sz == 0;
      if (pop) mRd = q.pop_front();
      else if (zr) mRd = '0;
      if (acc) q.push_back(slotE[g]);
      if (acc) mDone = 1'b1;
      else if ((pop && sz == 1) || zr) mDone = 1'b0;
      if (g >= 0) slotV[g] = 0;
      for (int i = 0; i < LINES; i++) begin
        if (rxReq[i]) begin
          slotV[2*i] = 1;
          slotE[2*i] = mkRx(i, rxChar[i*8 +: 8], rxErr[i*3 +: 3]);
        end
        if (loopEn && txDone[i]) begin
          slotV[2*i+1] = 1;
          slotE[2*i+1] = mkLb(i, txChar[i*8 +: 8]);
        end
      end
    end
  endtask

  // one clock: update reference, cross the edge, compare, drop pulses
  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk("R9 fill count vs reference", int'(fillCount), q.size());
    chk("R3 done flag vs reference", int'(rxDone), int'(mDone));
    chk("R5 drop pulse vs reference", int'(rxDropped), int'(mDrop));
    chk("R1 read word vs reference", int'(rdWord), int'(mRd));
    rxReq = '0; txDone = '0; rdStrobe = 1'b0; masterClear = 1'b0;
  endtask

  task automatic rxPulse(int line, logic [7:0] ch, logic [2:0] err);
    rxReq[line] = 1'b1;
    rxChar[line*8 +: 8] = ch;
    rxErr[line*3 +: 3]  = err;
  endtask

  task automatic readOne(string tag, logic [15:0] exp);
    rdStrobe = 1'b1;
    tick();
    chk(tag, int'(rdWord), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] expOrder [5];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6 reset state
    chk("R6 reset count", int'(fillCount), 0);
    chk("R6 reset done", int'(rxDone), 0);
    chk("R6 reset read word", int'(rdWord), 0);

    // R4 empty read
    rdStrobe = 1'b1;
    tick();
    chk("R4 empty read word", int'(rdWord), 0);
    chk("R4 empty read done", int'(rxDone), 0);
    chk("R4 empty read count", int'(fillCount), 0);

    // R2 layout, R9 latency, R3 set/clear
    rxPulse(2, 8'hA5, 3'b010);
    tick();
    chk("R9 count one edge after request", int'(fillCount), 0);
    tick();
    chk("R9 count two edges after request", int'(fillCount), 1);
    chk("R3 done set by push", int'(rxDone), 1);
    readOne("R2 entry layout line 2 framing", 16'hA2A5);
    chk("R3 done cleared at empty", int'(rxDone), 0);

    // R7 loopback entry
    loopEn = 1'b1;
    txDone[3] = 1'b1; txChar[3*8 +: 8] = 8'h3C;
    tick(); tick();
    readOne("R7 loopback entry", 16'h833C);

    // R11 loopback disabled
    loopEn = 1'b0;
    txDone = '1;
    tick(); tick(); tick();
    chk("R11 tx done ignored without loopback", int'(fillCount), 0);

    // R8 arbitration order
    loopEn = 1'b1;
    for (int i = 0; i < LINES; i++) rxPulse(i, 8'(8'h10 + i), 3'b000);
    txDone[1] = 1'b1; txChar[1*8 +: 8] = 8'h77;
    tick();
    repeat (5) tick();
    chk("R8 all five queued", int'(fillCount), 5);
    expOrder = '{16'h8010, 16'h8111, 16'h8177, 16'h8212, 16'h8313};
    for (int k = 0; k < 5; k++) readOne("R8 service order", expOrder[k]);
    loopEn = 1'b0;

    // R10 pending slot replaced
    for (int i = 0; i < LINES; i++) rxPulse(i, 8'(8'h20 + i), 3'b000);
    tick();
    rxPulse(3, 8'h99, 3'b000);
    tick();
    repeat (5) tick();
    chk("R10 replaced slot count", int'(fillCount), 4);
    expOrder = '{16'h8020, 16'h8121, 16'h8222, 16'h8399, 16'h0000};
    for (int k = 0; k < 4; k++) readOne("R10 replaced slot order", expOrder[k]);

    // R9 push and pop at the same edge
    rxPulse(0, 8'h41, 3'b000);
    tick(); tick();
    rxPulse(1, 8'h42, 3'b000);
    tick();
    chk("R9 count before overlap", int'(fillCount), 1);
    readOne("R9 overlapped read word", 16'h8041);
    chk("R9 count unchanged by push and pop", int'(fillCount), 1);
    readOne("R9 second word", 16'h8142);

    // R5 full and discard
    for (int k = 0; k < DEPTH + 2; k++) begin
      rxPulse(0, 8'(k), 3'b000);
      tick();
    end
    tick();
    chk("R5 count at full", int'(fillCount), DEPTH);
    chk("R5 drop pulse after discard", int'(rxDropped), 1);
    tick();
    chk("R5 drop pulse one cycle", int'(rxDropped), 0);
    for (int k = 0; k < DEPTH; k++) readOne("R5 contents kept at full", 16'(16'h8000 | k));
    chk("R1 empty after drain", int'(fillCount), 0);

    // R6 master clear with stored and pending words
    rxPulse(0, 8'h55, 3'b001);
    tick(); tick();
    rxPulse(2, 8'h66, 3'b000);
    tick();
    masterClear = 1'b1;
    rxPulse(1, 8'h67, 3'b000);
    tick();
    chk("R6 clear count", int'(fillCount), 0);
    chk("R6 clear done", int'(rxDone), 0);
    chk("R6 clear read word", int'(rdWord), 0);
    tick(); tick();
    chk("R6 pending discarded", int'(fillCount), 0);
    readOne("R6 read after clear", 16'h0000);

    // random phases against the reference
    for (int c = 0; c < 6000; c++) begin
      int rdRate;
      rdRate = ((c / 1000) % 2 == 0) ? 2 : 24;
      for (int i = 0; i < LINES; i++) begin
        if ($urandom_range(5) == 0) rxPulse(i, 8'($urandom), 3'($urandom));
        if ($urandom_range(7) == 0) begin
          txDone[i] = 1'b1;
          txChar[i*8 +: 8] = 8'($urandom);
        end
      end
      if ($urandom_range(63) == 0) loopEn = ~loopEn;
      rdStrobe    = ($urandom_range(rdRate - 1) == 0);
      masterClear = ($urandom_range(799) == 0);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule